// File: doc/BRIEF.md
# Capture Channel Input Conditioner

This block is the front end of a single timer capture channel. One of four candidate signals is chosen as the channel input. That choice is one external pin or one of three on-chip digital signals. The chosen signal is brought into the timer clock domain and can then pass through a noise filter whose sampling rate is programmable. An edge detector follows, and its output is one clock-wide event pulse for each qualifying transition. The timer core that owns the counters and flags consumes that pulse.

The filter samples the synchronized level on a divided tick. It adopts a new level only after three samples in a row agree. Otherwise the old level is kept. A bypass control skips the filter entirely. Some events would be artefacts of reconfiguration rather than real transitions on the input. To suppress them, a short suppression window starts whenever the channel is disabled, the source changes or the filter mode changes. During that window the filter and the edge detector track the new signal without reporting events.

Top module: `cap_conditioner`

## Requirements
- R1: `src_sel_i` picks the input. 00 selects `pin_i`, and 01, 10 and 11 select `int_src_i[0]`, `int_src_i[1]` and `int_src_i[2]`. Transitions on any input that is not selected never produce an event.
- R2: While `chan_en_i` is 0, `event_o` stays 0 whatever the inputs do.
- R3: With `edge_sel_i` = 00, only 0-to-1 transitions of the conditioned level produce an event.
- R4: With `edge_sel_i` = 01, only 1-to-0 transitions produce an event.
- R5: With `edge_sel_i` = 10 or 11, both transitions produce an event, including transitions on consecutive cycles.
- R6: `event_o` is 0 after reset. With the filter bypassed (`filt_dis_i` = 1), a change applied before clock edge n gives an `event_o` that is high for exactly the one cycle following edge n+2.
- R7: With the filter on and divide code 00, a level change is accepted after three consecutive equal samples, and the event follows edge n+5. A pulse lasting 2 cycles is dropped. A pulse lasting 3 cycles yields two events, three cycles apart.
- R8: `filt_div_i` sets the sample interval: 00 gives 1 clock, 01 gives 2, 10 gives 4 and 11 gives 16. For example, a 7-cycle pulse passes at divide 2 but is dropped at divide 4. A 30-cycle pulse passes at divide 4 but is dropped at divide 16. A sustained change always yields exactly one event.
- R9: Switching the source, toggling `filt_dis_i` or re-enabling the channel never produces an event. The block suppresses events for SYNC_STAGES+2 edges after such a change, and meanwhile loads the filter and the previous-level register with the current level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_en_i | input | 1 | Channel enable |
| src_sel_i | input | 2 | Input source select |
| filt_dis_i | input | 1 | 1 bypasses the noise filter |
| filt_div_i | input | 2 | Filter sample interval code |
| edge_sel_i | input | 2 | Edge mode: 00 rise, 01 fall, 1x both |
| pin_i | input | 1 | External pin (asynchronous) |
| int_src_i | input | 3 | On-chip candidate sources |
| event_o | output | 1 | One-cycle capture event pulse |

## Verification
With the filter bypassed, an event is due in the third cycle after the input is driven. This covers two synchronizer flops and the registered output. With the filter on at divide 1, the event is due in the sixth cycle. The driver pushes exactly that cycle into a queue. The monitor pops it on the falling edge, so an early, late, stretched or missing pulse is reported. At divide 2, 4 and 16 the phase of the sample tick is not visible at the ports. Those cases therefore count events inside a window long enough for three ticks, and the pulse lengths are chosen so that the outcome does not depend on the tick phase.

// File: rtl/cap_cond_pkg.sv
package cap_cond_pkg;
  localparam int DIV_W = 5;

  function automatic logic [DIV_W-1:0] div_limit(input logic [1:0] code);
    case (code)
      2'b00:   div_limit = 5'd1;
      2'b01:   div_limit = 5'd2;
      2'b10:   div_limit = 5'd4;
      default: div_limit = 5'd16;
    endcase
  endfunction

  function automatic logic edge_hit(input logic [1:0] mode, input logic prev, input logic cur);
    case (mode)
      2'b00:   edge_hit = cur & ~prev;
      2'b01:   edge_hit = prev & ~cur;
      default: edge_hit = cur ^ prev;
    endcase
  endfunction
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cap_filter.sv
module cap_filter
  import cap_cond_pkg::*;
#(
  parameter int SAMPLES = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       flush_i,
  input  logic [1:0] div_i,
  input  logic       d_i,
  output logic       lvl_o
);
  localparam int HW = SAMPLES - 1;

  logic [DIV_W-1:0] div_cnt_q;
  logic [HW-1:0]    hist_q;
  logic             lvl_q;
  logic             tick;
  logic             agree;

  assign tick  = div_cnt_q >= (div_limit(div_i) - 5'd1);
  assign agree = ((&hist_q) && d_i) || (!(|hist_q) && !d_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_cnt_q <= '0;
      hist_q    <= '0;
      lvl_q     <= 1'b0;
    end else if (flush_i) begin
      div_cnt_q <= '0;
      hist_q    <= {HW{d_i}};
      lvl_q     <= d_i;
    end else begin
      div_cnt_q <= tick ? '0 : div_cnt_q + 1'b1;
      if (tick) begin
        hist_q <= {hist_q[HW-2:0], d_i};
        if (agree) lvl_q <= d_i;
      end
    end
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/cap_edge.sv
module cap_edge
  import cap_cond_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lvl_i,
  input  logic       mask_i,
  input  logic [1:0] mode_i,
  output logic       event_o
);
  logic prev_q, ev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      ev_q   <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      ev_q   <= !mask_i && edge_hit(mode_i, prev_q, lvl_i);
    end
  end

  assign event_o = ev_q;
endmodule

// File: rtl/cap_conditioner.sv
module cap_conditioner #(
  parameter int SYNC_STAGES  = 2,
  parameter int FILT_SAMPLES = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       chan_en_i,
  input  logic [1:0] src_sel_i,
  input  logic       filt_dis_i,
  input  logic [1:0] filt_div_i,
  input  logic [1:0] edge_sel_i,
  input  logic       pin_i,
  input  logic [2:0] int_src_i,
  output logic       event_o
);
  localparam int BLANK_LEN = SYNC_STAGES + 2;
  localparam int BW        = $clog2(BLANK_LEN + 1);

  logic          sel_in, sync_lvl, filt_lvl, lvl;
  logic [1:0]    src_q;
  logic          fdis_q;
  logic [BW-1:0] blank_cnt_q;
  logic          resync, blank;

  assign sel_in = (src_sel_i == 2'd0) ? pin_i : int_src_i[src_sel_i - 2'd1];

  // any reconfiguration opens a window in which levels are reseeded, not reported
  assign resync = !chan_en_i || (src_sel_i != src_q) || (filt_dis_i != fdis_q);
  assign blank  = resync || (blank_cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q       <= '0;
      fdis_q      <= 1'b0;
      blank_cnt_q <= BW'(BLANK_LEN);
    end else begin
      src_q  <= src_sel_i;
      fdis_q <= filt_dis_i;
      if (resync)                 blank_cnt_q <= BW'(BLANK_LEN);
      else if (blank_cnt_q != '0) blank_cnt_q <= blank_cnt_q - 1'b1;
    end
  end

  cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (sel_in),
    .q_o   (sync_lvl)
  );

  cap_filter #(.SAMPLES(FILT_SAMPLES)) u_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flush_i(blank),
    .div_i  (filt_div_i),
    .d_i    (sync_lvl),
    .lvl_o  (filt_lvl)
  );

  assign lvl = filt_dis_i ? sync_lvl : filt_lvl;

  cap_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lvl),
    .mask_i (blank),
    .mode_i (edge_sel_i),
    .event_o(event_o)
  );
endmodule

// File: rtl/cap_cond_chk.sv
module cap_cond_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       chan_en_i,
  input logic [1:0] src_sel_i,
  input logic       filt_dis_i,
  input logic       event_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assert_off_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chan_en_i |=> !event_o);

  assert_wake_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $rose(chan_en_i)) |=> !event_o);

  assert_src_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && (src_sel_i != $past(src_sel_i))) |=> !event_o);

  assert_mode_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && (filt_dis_i != $past(filt_dis_i))) |=> !event_o);

  assert_reset_low_R6: assert property (@(posedge clk_i)
    !rst_ni |=> !event_o);
endmodule

bind cap_conditioner cap_cond_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .chan_en_i (chan_en_i),
  .src_sel_i (src_sel_i),
  .filt_dis_i(filt_dis_i),
  .event_o   (event_o)
);

// File: tb/sim_cap_conditioner.sv
`timescale 1ns/1ps
module sim_cap_conditioner;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       chan_en = 1'b1, filt_dis = 1'b1, pin = 1'b0;
  logic [1:0] src_sel = 2'd0, filt_div = 2'd0, edge_sel = 2'd0;
  logic [2:0] int_src = 3'd0;
  logic       event_w;

  int cyc = 0, errors = 0, checks = 0;
  int exp_q[$];
  bit win_mode = 0;
  int win_cnt = 0;
  string cur_req = "R6";

  cap_conditioner u0 (
    .clk_i(clk), .rst_ni(rst_n), .chan_en_i(chan_en), .src_sel_i(src_sel),
    .filt_dis_i(filt_dis), .filt_div_i(filt_div), .edge_sel_i(edge_sel),
    .pin_i(pin), .int_src_i(int_src), .event_o(event_w)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: pops expected event cycles
  always @(negedge clk) if (rst_n) begin
    if (exp_q.size() > 0 && exp_q[0] < cyc) begin
      check(0, cur_req, -1, exp_q[0]);
      void'(exp_q.pop_front());
    end
    if (event_w) begin
      if (win_mode) win_cnt++;
      else if (exp_q.size() > 0 && exp_q[0] == cyc) begin
        check(1, cur_req, cyc, cyc);
        void'(exp_q.pop_front());
      end else check(0, cur_req, cyc, (exp_q.size() > 0) ? exp_q[0] : -1);
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // which: 0 = pin, 1..3 = int_src index+1
  task automatic drive(input int which, input logic v, input int lat, input bit expect_ev);
    @(negedge clk);
    if (which == 0) pin = v; else int_src[which-1] = v;
    if (expect_ev) exp_q.push_back(cyc + lat);
  endtask

  task automatic win_open();
    win_cnt = 0;
    win_mode = 1;
  endtask

  task automatic win_close(input int exp, input string req);
    win_mode = 0;
    check(win_cnt == exp, req, win_cnt, exp);
  endtask

  task automatic drain(input string req);
    idle(10);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    idle(3);
    check(event_w == 1'b0, "R6", event_w, 0);
    rst_n = 1'b1;
    idle(10);
    check(event_w == 1'b0, "R6", event_w, 0);

    // R3 rising only, bypass latency R6
    cur_req = "R3";
    drive(0, 1, 3, 1); idle(8);
    drive(0, 0, 3, 0); drain("R3");

    // R4 falling only
    cur_req = "R4";
    @(negedge clk) edge_sel = 2'b01; idle(5);
    drive(0, 1, 3, 0); idle(8);
    drive(0, 0, 3, 1); drain("R4");

    // R5 both edges, codes 10 and 11, back-to-back
    cur_req = "R5";
    @(negedge clk) edge_sel = 2'b10; idle(5);
    drive(0, 1, 3, 1); idle(8);
    drive(0, 0, 3, 1); idle(8);
    @(negedge clk) edge_sel = 2'b11; idle(5);
    drive(0, 1, 3, 1);
    drive(0, 0, 3, 1); drain("R5");

    // R1 source selection
    cur_req = "R1";
    win_open(); @(negedge clk) src_sel = 2'd1; idle(10); win_close(0, "R9");
    drive(0, 1, 3, 0); idle(8);
    drive(1, 1, 3, 1); idle(8);
    drive(1, 0, 3, 1); idle(8);
    drive(2, 1, 3, 0); drain("R1");
    win_open(); @(negedge clk) src_sel = 2'd2; idle(10); win_close(0, "R9");
    drive(2, 0, 3, 1); idle(8);
    drive(3, 1, 3, 0); drain("R1");
    win_open(); @(negedge clk) src_sel = 2'd3; idle(10); win_close(0, "R9");
    drive(3, 0, 3, 1); idle(8);
    drive(0, 0, 3, 0); drain("R1");
    win_open(); @(negedge clk) src_sel = 2'd0; idle(10); win_close(0, "R9");

    // R2 disabled channel, then quiet re-enable (R9)
    win_open();
    @(negedge clk) chan_en = 1'b0;
    drive(0, 1, 3, 0); idle(6);
    drive(0, 0, 3, 0); idle(6);
    drive(0, 1, 3, 0); idle(10);
    win_close(0, "R2");
    win_open(); @(negedge clk) chan_en = 1'b1; idle(10); win_close(0, "R9");
    cur_req = "R2";
    drive(0, 0, 3, 1); drain("R2");

    // R7 filter at divide 1
    win_open(); @(negedge clk) filt_dis = 1'b0; idle(10); win_close(0, "R9");
    cur_req = "R7";
    drive(0, 1, 6, 1); idle(12);
    drive(0, 0, 6, 0); idle(1); drive(0, 1, 6, 0); idle(12);
    drive(0, 0, 6, 1); idle(2); drive(0, 1, 6, 1); drain("R7");

    // R8 divided sampling: phase-independent windows
    @(negedge clk) filt_div = 2'b01; idle(40);
    win_open(); drive(0, 0, 0, 0); idle(6); drive(0, 1, 0, 0); idle(60); win_close(2, "R8");
    @(negedge clk) filt_div = 2'b10; idle(40);
    win_open(); drive(0, 0, 0, 0); idle(6); drive(0, 1, 0, 0); idle(60); win_close(0, "R8");
    win_open(); drive(0, 0, 0, 0); idle(29); drive(0, 1, 0, 0); idle(60); win_close(2, "R8");
    @(negedge clk) filt_div = 2'b11; idle(100);
    win_open(); drive(0, 0, 0, 0); idle(29); drive(0, 1, 0, 0); idle(120); win_close(0, "R8");
    win_open(); drive(0, 0, 0, 0); idle(120); win_close(1, "R8");

    // R9 filter mode change back to bypass with differing internal state
    win_open(); @(negedge clk) filt_dis = 1'b1; idle(10); win_close(0, "R9");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20 * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule